// File: doc/BRIEF.md
# Prioritized Channel Fault Recorder

This block keeps a two-bit health status for each output channel of a multi-channel low-side switch. Each channel supplies an active-low on/off command (already synchronized), a flag from a drain-voltage comparator that is high when the drain sits below its reference, a flag from a load-current comparator that is high when the current is below the open-load reference, and a one-cycle short-to-battery/overtemperature event from the protection logic. The comparator flags are valid only in one switch state: the drain flag while the channel is off, the undercurrent flag while it is on. A single retriggerable counter per channel filters whichever flag applies, so short spikes and switching transients are never recorded.

A qualified open-load condition is stored at once if it goes away while the channel stays on (sporadic). If it is still present when the channel is commanded off, it is stored on that turn-off edge (static). Each status field can only move towards a more severe code. A clear pulse from the serial read path, the synchronous reset and the undervoltage input return every field to "no failure". When a clear and a new fault fall in the same cycle, the new fault is kept. A registered summary flag tells the serial interface whether any channel holds a fault.

Top module: `chan_fault_recorder`

## Requirements
- R1: With the channel off, a drain-low flag seen on FILT_LEN consecutive clock edges is stored as code 00 on the next edge; a shorter run stores nothing.
- R2: The drain-low flag has no effect while the channel is on, and the undercurrent flag has no effect while it is off.
- R3: Any change of the channel command restarts that channel's filter, so a condition counts only from the first edge after the last command change.
- R4: A qualified open-load condition still present when the command goes from on (0) to off (1) is stored as code 10 on that edge, and not earlier.
- R5: A qualified open-load condition that disappears while the channel stays on is stored as code 10 on the first edge at which the undercurrent flag is seen low.
- R6: A short-to-battery event is stored as code 01 on the next clock edge.
- R7: Severity from highest to lowest is 01, 00, 10, 11; a field changes only to a more severe code unless it is cleared.
- R8: Codes are 11 no failure, 10 open load, 01 short to battery or overtemperature, 00 short to ground; channel 1 occupies status_o[7:6], channel 2 [5:4], channel 3 [3:2], channel 4 [1:0] (channel k uses index k-1 of every per-channel input).
- R9: A clear pulse sets every field to 11 on the next edge, except that a fault detected in the same cycle is stored instead.
- R10: Reset or undervoltage sets every field to 11 on the next edge, keeps it there while asserted, and restarts all filters.
- R11: any_fail_o is high exactly when some field of status_o differs from 11, updated in the same cycle as status_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (nominally 325 kHz) |
| rst | input | 1 | Synchronous active-high reset |
| uv_i | input | 1 | Undervoltage, acts as a synchronous reset while high |
| cmd_n_i | input | NUM_CH | Active-low on command per channel |
| drain_low_i | input | NUM_CH | Drain below short-to-ground reference |
| under_cur_i | input | NUM_CH | Load current below open-load reference |
| bat_short_i | input | NUM_CH | Short-to-battery or overtemperature event |
| rd_clr_i | input | 1 | Clear pulse from the serial read path |
| status_o | output | 2*NUM_CH | Registered status fields |
| any_fail_o | output | 1 | Registered: some field is not 11 |

## Verification
Short-to-battery events and clears appear one edge after they are seen. A short to ground appears on edge FILT_LEN+1 of an unbroken run, and that count starts one edge after a command change. A static open-load appears on the turn-off edge. A sporadic one appears on the edge where the flag is seen low, once the condition has been held for at least FILT_LEN+2 edges after turn-on. The bench applies each vector at a falling edge and counts the rising edges that the vector is held. It samples at the following falling edge. Vector lengths are set to one edge before or at the due edge, so the checks show both "not yet" and "now".

// File: rtl/fault_rec_pkg.sv
package fault_rec_pkg;

  typedef enum logic [1:0] {
    ST_SHORT_GND = 2'b00,
    ST_SHORT_BAT = 2'b01,
    ST_OPEN_LOAD = 2'b10,
    ST_HEALTHY   = 2'b11
  } stat_e;

  // Severity rank: larger value wins.
  function automatic logic [1:0] sev_rank(input stat_e code);
    case (code)
      ST_SHORT_BAT: sev_rank = 2'd3;
      ST_SHORT_GND: sev_rank = 2'd2;
      ST_OPEN_LOAD: sev_rank = 2'd1;
      default:      sev_rank = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/chan_spike_filter.sv
module chan_spike_filter #(
  parameter int LEN = 64
) (
  input  logic clk,
  input  logic kill_i,
  input  logic restart_i,
  input  logic cond_i,
  output logic qual_o
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LIMIT = CW'(LEN);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (kill_i || restart_i || !cond_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign qual_o = (cnt_q == LIMIT);

  // R3: a restart means the next cycle is never qualified
  a_r3_restart_clears: assert property (@(posedge clk) disable iff (kill_i)
    restart_i |=> !qual_o);

endmodule

// File: rtl/chan_fault_classify.sv
module chan_fault_classify #(
  parameter int FILT_LEN = 64
) (
  input  logic clk,
  input  logic kill_i,
  input  logic on_i,
  input  logic drain_low_i,
  input  logic under_cur_i,
  output logic ev_scg_o,
  output logic ev_ol_o
);
  logic on_q;
  logic arm_q;
  logic toggle;
  logic cond;
  logic qual;
  logic ol_sporadic;
  logic ol_static;

  always_ff @(posedge clk) begin
    if (kill_i) on_q <= 1'b0;
    else        on_q <= on_i;
  end

  assign toggle = on_i ^ on_q;
  assign cond   = on_i ? under_cur_i : drain_low_i;

  chan_spike_filter #(.LEN(FILT_LEN)) filt_i (
    .clk       (clk),
    .kill_i    (kill_i),
    .restart_i (toggle),
    .cond_i    (cond),
    .qual_o    (qual)
  );

  // Qualified while off: short to ground, reported every qualified cycle.
  assign ev_scg_o = qual && !on_q;

  // Open load is armed when qualified while on, committed later.
  assign ol_sporadic = arm_q && on_q && on_i && !under_cur_i;
  assign ol_static   = arm_q && on_q && !on_i;
  assign ev_ol_o     = ol_sporadic || ol_static;

  always_ff @(posedge clk) begin
    if (kill_i || toggle || ev_ol_o) arm_q <= 1'b0;
    else if (qual && on_q)           arm_q <= 1'b1;
  end

  a_r1_scg_only_off: assert property (@(posedge clk) disable iff (kill_i)
    ev_scg_o |-> !$past(on_i));

  a_r2_ol_only_on: assert property (@(posedge clk) disable iff (kill_i)
    ev_ol_o |-> $past(on_i));

  a_r4_static_at_off: assert property (@(posedge clk) disable iff (kill_i)
    (arm_q && $fell(on_i)) |-> ev_ol_o);

endmodule

// File: rtl/fault_field_store.sv
module fault_field_store
  import fault_rec_pkg::*;
(
  input  logic  clk,
  input  logic  kill_i,
  input  logic  clr_i,
  input  logic  ev_scb_i,
  input  logic  ev_scg_i,
  input  logic  ev_ol_i,
  output stat_e field_o,
  output stat_e field_nxt_o
);
  stat_e field_q;
  stat_e cand;
  stat_e base;

  always_comb begin
    cand = ST_HEALTHY;
    if (ev_ol_i)  cand = ST_OPEN_LOAD;
    if (ev_scg_i) cand = ST_SHORT_GND;
    if (ev_scb_i) cand = ST_SHORT_BAT;
    base = clr_i ? ST_HEALTHY : field_q;
    field_nxt_o = (sev_rank(cand) > sev_rank(base)) ? cand : base;
  end

  always_ff @(posedge clk) begin
    if (kill_i) field_q <= ST_HEALTHY;
    else        field_q <= field_nxt_o;
  end

  assign field_o = field_q;

  a_r7_no_downgrade: assert property (@(posedge clk) disable iff (kill_i)
    !clr_i |=> sev_rank(field_q) >= sev_rank($past(field_q)));

  a_r6_bat_stored: assert property (@(posedge clk) disable iff (kill_i)
    ev_scb_i |=> field_q == ST_SHORT_BAT);

  a_r9_clear_idle: assert property (@(posedge clk) disable iff (kill_i)
    (clr_i && !ev_scb_i && !ev_scg_i && !ev_ol_i) |=> field_q == ST_HEALTHY);

endmodule

// File: rtl/chan_fault_recorder.sv
module chan_fault_recorder
  import fault_rec_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int FILT_LEN = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  uv_i,
  input  logic [NUM_CH-1:0]     cmd_n_i,
  input  logic [NUM_CH-1:0]     drain_low_i,
  input  logic [NUM_CH-1:0]     under_cur_i,
  input  logic [NUM_CH-1:0]     bat_short_i,
  input  logic                  rd_clr_i,
  output logic [2*NUM_CH-1:0]   status_o,
  output logic                  any_fail_o
);
  localparam int SW = 2 * NUM_CH;

  logic          kill;
  logic [SW-1:0] nxt_all;

  assign kill = rst || uv_i;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic  ev_scg;
    logic  ev_ol;
    stat_e fld;
    stat_e fld_nxt;

    chan_fault_classify #(.FILT_LEN(FILT_LEN)) cls_i (
      .clk         (clk),
      .kill_i      (kill),
      .on_i        (!cmd_n_i[i]),
      .drain_low_i (drain_low_i[i]),
      .under_cur_i (under_cur_i[i]),
      .ev_scg_o    (ev_scg),
      .ev_ol_o     (ev_ol)
    );

    fault_field_store st_i (
      .clk         (clk),
      .kill_i      (kill),
      .clr_i       (rd_clr_i),
      .ev_scb_i    (bat_short_i[i]),
      .ev_scg_i    (ev_scg),
      .ev_ol_i     (ev_ol),
      .field_o     (fld),
      .field_nxt_o (fld_nxt)
    );

    // Channel index 0 sits in the most significant field.
    assign status_o[2*(NUM_CH-1-i) +: 2] = fld;
    assign nxt_all[2*(NUM_CH-1-i) +: 2]  = fld_nxt;
  end

  always_ff @(posedge clk) begin
    if (kill) any_fail_o <= 1'b0;
    else      any_fail_o <= (nxt_all != '1);
  end

  a_r11_any_matches: assert property (@(posedge clk) disable iff (kill)
    any_fail_o == (status_o != '1));

  a_r10_kill_clears: assert property (@(posedge clk)
    kill |=> (status_o == '1) && !any_fail_o);

endmodule

// File: tb/chan_fault_recorder_tb.sv
module chan_fault_recorder_tb_top;
  localparam int NCH  = 4;
  localparam int FILT = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           uv  = 1'b0;
  logic [NCH-1:0] cmd_n = '1;
  logic [NCH-1:0] dlow  = '0;
  logic [NCH-1:0] ucur  = '0;
  logic [NCH-1:0] bshort = '0;
  logic           clr = 1'b0;
  logic [7:0]     stat;
  logic           anyf;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  chan_fault_recorder #(.NUM_CH(NCH), .FILT_LEN(FILT)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .uv_i        (uv),
    .cmd_n_i     (cmd_n),
    .drain_low_i (dlow),
    .under_cur_i (ucur),
    .bat_short_i (bshort),
    .rd_clr_i    (clr),
    .status_o    (stat),
    .any_fail_o  (anyf)
  );

  // {req[3:0], cmd_n, drain_low, under_cur, bat_short, clr, edges[7:0], expected[7:0]}
  // Bit k of each 4-bit field drives channel k+1.
  localparam int NV = 26;
  localparam logic [36:0] VEC [NV] = '{
    {4'd8,  4'b1111, 4'b0000, 4'b0000, 4'b0000, 1'b0, 8'd2, 8'hFF}, // R8 idle
    {4'd1,  4'b1111, 4'b0001, 4'b0000, 4'b0000, 1'b0, 8'd4, 8'hFF}, // R1 not yet
    {4'd1,  4'b1111, 4'b0001, 4'b0000, 4'b0000, 1'b0, 8'd1, 8'h3F}, // R1 stored, R8 ch1 field
    {4'd9,  4'b1111, 4'b0000, 4'b0000, 4'b0000, 1'b1, 8'd1, 8'h3F}, // R9 new fault beats clear
    {4'd9,  4'b1111, 4'b0000, 4'b0000, 4'b0000, 1'b1, 8'd1, 8'hFF}, // R9 clear
    {4'd1,  4'b1111, 4'b0010, 4'b0000, 4'b0000, 1'b0, 8'd3, 8'hFF}, // R1 short run
    {4'd1,  4'b1111, 4'b0000, 4'b0000, 4'b0000, 1'b0, 8'd5, 8'hFF}, // R1 short run ignored
    {4'd2,  4'b1111, 4'b0000, 4'b0010, 4'b0000, 1'b0, 8'd8, 8'hFF}, // R2 undercurrent while off
    {4'd2,  4'b1011, 4'b0100, 4'b0100, 4'b0000, 1'b0, 8'd8, 8'hFF}, // R2/R4 drain-low while on, static pending
    {4'd4,  4'b1111, 4'b0000, 4'b0100, 4'b0000, 1'b0, 8'd1, 8'hFB}, // R4 stored at turn-off
    {4'd9,  4'b1111, 4'b0000, 4'b0000, 4'b0000, 1'b1, 8'd1, 8'hFF}, // R9
    {4'd5,  4'b0111, 4'b0000, 4'b1000, 4'b0000, 1'b0, 8'd8, 8'hFF}, // R5 armed, not stored
    {4'd5,  4'b0111, 4'b0000, 4'b0000, 4'b0000, 1'b0, 8'd1, 8'hFE}, // R5 sporadic stored
    {4'd5,  4'b0111, 4'b0000, 4'b0000, 4'b0000, 1'b0, 8'd3, 8'hFE}, // R5 held
    {4'd7,  4'b1111, 4'b1000, 4'b0000, 4'b0000, 1'b0, 8'd5, 8'hFE}, // R7 counting after toggle
    {4'd7,  4'b1111, 4'b1000, 4'b0000, 4'b0000, 1'b0, 8'd1, 8'hFC}, // R7 00 over 10
    {4'd6,  4'b1111, 4'b0000, 4'b0000, 4'b1000, 1'b0, 8'd1, 8'hFD}, // R6 01 wins
    {4'd7,  4'b1111, 4'b1000, 4'b0000, 4'b0000, 1'b0, 8'd6, 8'hFD}, // R7 no downgrade
    {4'd7,  4'b1111, 4'b0000, 4'b0000, 4'b0000, 1'b0, 8'd3, 8'hFD}, // R7
    {4'd9,  4'b1111, 4'b0000, 4'b0000, 4'b0000, 1'b1, 8'd1, 8'hFF}, // R9
    {4'd3,  4'b1111, 4'b0001, 4'b0000, 4'b0000, 1'b0, 8'd3, 8'hFF}, // R3 partial count
    {4'd3,  4'b1110, 4'b0001, 4'b0000, 4'b0000, 1'b0, 8'd1, 8'hFF}, // R3 command change
    {4'd3,  4'b1111, 4'b0001, 4'b0000, 4'b0000, 1'b0, 8'd3, 8'hFF}, // R3 restarted
    {4'd3,  4'b1111, 4'b0001, 4'b0000, 4'b0000, 1'b0, 8'd3, 8'h3F}, // R3 full run
    {4'd9,  4'b1111, 4'b0000, 4'b0000, 4'b0000, 1'b1, 8'd1, 8'h3F}, // R9 same-cycle detection
    {4'd9,  4'b1111, 4'b0000, 4'b0000, 4'b0000, 1'b1, 8'd1, 8'hFF}  // R9
  };

  task automatic check(input logic [7:0] exp, input int req);
    logic exp_any;
    exp_any = (exp != 8'hFF); // R11
    checks++;
    if (stat !== exp || anyf !== exp_any) begin
      failures++;
      $display("FAIL R%0d: status=%h any=%b expected status=%h any=%b",
               req, stat, anyf, exp, exp_any);
    end
  endtask

  task automatic idle_inputs();
    cmd_n = '1; dlow = '0; ucur = '0; bshort = '0; clr = 1'b0;
  endtask

  initial begin
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check(8'hFF, 10); // R10 reset state

    for (int v = 0; v < NV; v++) begin
      cmd_n  = VEC[v][32:29];
      dlow   = VEC[v][28:25];
      ucur   = VEC[v][24:21];
      bshort = VEC[v][20:17];
      clr    = VEC[v][16];
      repeat (int'(VEC[v][15:8])) @(posedge clk);
      @(negedge clk);
      check(VEC[v][7:0], int'(VEC[v][36:33]));
    end

    // R10: undervoltage clears and holds
    idle_inputs();
    bshort = 4'b0010;
    @(negedge clk);
    check(8'hDF, 6); // R6 channel 2 field
    uv = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(8'hFF, 10); // R10 held clear despite event
    uv = 1'b0; bshort = '0;
    @(negedge clk);
    check(8'hFF, 10);

    // R10: reset restarts filter
    dlow = 4'b0001;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(8'hFF, 10); // count restarted
    @(negedge clk);
    check(8'h3F, 10); // R10 then R1 completes
    idle_inputs();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule